// File: doc/BRIEF.md
# Multi-Source Configurable Set/Reset Latch

This block is a clocked set/reset latch for a microcontroller-style peripheral. Its set side and its reset side each have four hardware sources: one external input pin, a single-cycle strobe from a periodic tick generator, and the outputs of two comparators. Every source is gated by its own bit in an 8-bit control register. Software writes that register over a simple write port and reads it back.

The effective set is the OR of the enabled set sources and a one-cycle software set pulse. The effective reset is formed the same way from the reset sources and a software clear pulse. When both are active in the same cycle, reset wins. The pin and the two comparator outputs are asynchronous, so each passes through a synchronizer chain before the gating. The tick and the software pulses are already synchronous and are used directly.

A module enable input holds the latch at 0 while it is low. Two output-enable inputs drive the true output and the inverted output onto their ports. A disabled port reads 0.

Top module: `srq_multi_latch`

## Requirements
- R1: A write with `wr_en` high loads `wr_data` into the control register at the clock edge, and `rd_data` returns that value from the next cycle on. The bit map is: bit 7 pin set, bit 6 tick set, bit 5 comparator B set, bit 4 comparator A set, bit 3 pin reset, bit 2 tick reset, bit 1 comparator B reset, bit 0 comparator A reset.
- R2: While `rst_n` is low, the control register reads 0x00 and the latch state is 0. This holds both at start-up and when reset is asserted during operation.
- R3: With bit 7 set, a high synchronized `pin_in` sets the latch. With bit 7 clear, `pin_in` has no effect on the set side.
- R4: With bit 6 set, a `tick` strobe sets the latch. With bit 6 clear, `tick` has no effect on the set side.
- R5: With bit 5 set, a high `cmp_b` sets the latch. With bit 4 set, a high `cmp_a` sets it. A comparator whose set bit is clear is ignored.
- R6: Bits 3, 2, 1 and 0 let `pin_in`, `tick`, `cmp_b` and `cmp_a` clear the latch. A source whose reset bit is clear does not clear the latch.
- R7: A one-cycle `sw_set` sets the latch and a one-cycle `sw_clr` clears it, whatever the control register holds.
- R8: When the effective set and the effective reset are both active in one cycle, the latch becomes 0.
- R9: While `mod_en` is low, the latch is forced to 0 at each clock edge and no set source can raise it.
- R10: `q_out` is the latch state when `q_oe` is 1 and 0 otherwise. `qn_out` is the inverted state when `qn_oe` is 1 and 0 otherwise.
- R11: A change on `pin_in`, `cmp_a` or `cmp_b` reaches the latch at the (SYNC_STAGES+1)-th rising edge after it is applied. `tick`, `sw_set` and `sw_clr` act at the first edge.
- R12: With no effective set and no effective reset, the latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| mod_en | input | 1 | Module enable; low forces the latch to 0 |
| q_oe | input | 1 | Enable for `q_out` |
| qn_oe | input | 1 | Enable for `qn_out` |
| sw_set | input | 1 | Software set pulse |
| sw_clr | input | 1 | Software clear pulse |
| pin_in | input | 1 | External asynchronous input |
| tick | input | 1 | Single-cycle periodic strobe |
| cmp_a | input | 1 | Comparator A output (asynchronous) |
| cmp_b | input | 1 | Comparator B output (asynchronous) |
| q_out | output | 1 | Gated latch output |
| qn_out | output | 1 | Gated inverted latch output |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, so an asynchronous source reaches the latch at the third rising edge. This short chain lets the bench hold the level inputs just long enough that they and the tick and software pulses land on the same edge. That makes the precedence cases between different source kinds observable in one cycle. The bench also counts edges one by one on a pin-driven set to confirm that the output stays low for exactly the chain length.

// File: rtl/srq_multi_latch.sv
module srq_multi_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       mod_en,
  input  logic       q_oe,
  input  logic       qn_oe,
  input  logic       sw_set,
  input  logic       sw_clr,
  input  logic       pin_in,
  input  logic       tick,
  input  logic       cmp_a,
  input  logic       cmp_b,
  output logic       q_out,
  output logic       qn_out
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [7:0] ctrl;
  logic [2:0] sy [SYNC_STAGES];
  logic       q;
  logic       pin_s, ca_s, cb_s, set_any, clr_any;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl <= '0;
    else if (wr_en) ctrl <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= '0;
    end else begin
      sy[0] <= {pin_in, cmp_b, cmp_a};
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
    end

  assign pin_s = sy[LAST][2];
  assign cb_s  = sy[LAST][1];
  assign ca_s  = sy[LAST][0];

  assign set_any = sw_set | (ctrl[7] & pin_s) | (ctrl[6] & tick)
                 | (ctrl[5] & cb_s) | (ctrl[4] & ca_s);
  assign clr_any = sw_clr | (ctrl[3] & pin_s) | (ctrl[2] & tick)
                 | (ctrl[1] & cb_s) | (ctrl[0] & ca_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  q <= 1'b0;
    else if (!mod_en || clr_any) q <= 1'b0;
    else if (set_any)            q <= 1'b1;

  assign rd_data = ctrl;
  assign q_out   = q & q_oe;
  assign qn_out  = ~q & qn_oe;
endmodule

// File: rtl/srq_multi_latch_chk.sv
module srq_multi_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       mod_en,
  input logic       sw_set,
  input logic       sw_clr,
  input logic       q,
  input logic       q_oe,
  input logic       qn_oe,
  input logic       q_out,
  input logic       qn_out
);
  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  p_reset_clear_r2: assert property (@(posedge clk)
    !rst_n |-> (rd_data == 8'h00 && !q));

  p_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && sw_set && !sw_clr && rd_data[3:0] == 4'h0) |=> q);

  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && sw_clr) |=> !q);

  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !q);

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_oe |-> !q_out) and (!qn_oe |-> !qn_out));

  p_rise_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(mod_en));
endmodule

bind srq_multi_latch srq_multi_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .mod_en(mod_en), .sw_set(sw_set), .sw_clr(sw_clr),
  .q(q), .q_oe(q_oe), .qn_oe(qn_oe), .q_out(q_out), .qn_out(qn_out)
);

// File: tb/srq_multi_latch_tb.sv
`timescale 1ns/1ps
module srq_multi_latch_tb;
  localparam int SYNC = 2;
  localparam int NV = 20;
  // {ctrl[7:0], pre_q, pin, cmp_b, cmp_a, tick, sw_set, sw_clr, expected_q}
  localparam logic [15:0] VEC [NV] = '{
    16'h8041, 16'h0040, 16'h4009, 16'h0008, 16'h2021,
    16'h1011, 16'h2010, 16'h08C0, 16'h0488, 16'h02A0,
    16'h0190, 16'h00F9, 16'h0005, 16'h0082, 16'h8840,
    16'h8042, 16'h4408, 16'h0081, 16'h0000, 16'hFF06
  };
  localparam string VREQ [NV] = '{
    "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R6", "R6", "R6",
    "R6", "R6", "R7", "R7", "R8", "R8", "R8", "R12", "R12", "R8"
  };

  logic clk = 0, rst_n = 1;
  logic wr_en = 0, mod_en = 1, q_oe = 1, qn_oe = 1, sw_set = 0, sw_clr = 0;
  logic pin_in = 0, tick = 0, cmp_a = 0, cmp_b = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic q_out, qn_out;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  srq_multi_latch #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mod_en(mod_en), .q_oe(q_oe), .qn_oe(qn_oe), .sw_set(sw_set), .sw_clr(sw_clr),
    .pin_in(pin_in), .tick(tick), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .q_out(q_out), .qn_out(qn_out));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    wr_en = 1; wr_data = v; @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input bit s);
    if (s) sw_set = 1; else sw_clr = 1;
    @(negedge clk); sw_set = 0; sw_clr = 0;
  endtask

  task automatic quiet();
    pin_in = 0; cmp_a = 0; cmp_b = 0; tick = 0; sw_set = 0; sw_clr = 0;
    write_ctrl(8'h00);
    repeat (SYNC + 1) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R2 ctrl at reset", rd_data, 8'h00);
    chk("R2 q at reset", {6'd0, q_out, qn_out}, 8'h01);
    rst_n = 1;
    @(negedge clk);

    write_ctrl(8'hA5);
    chk("R1 readback", rd_data, 8'hA5);
    write_ctrl(8'h5A);
    chk("R1 readback 2", rd_data, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      quiet();
      pulse(VEC[i][7]);
      write_ctrl(VEC[i][15:8]);
      pin_in = VEC[i][6]; cmp_b = VEC[i][5]; cmp_a = VEC[i][4];
      repeat (SYNC) @(negedge clk);
      tick = VEC[i][3]; sw_set = VEC[i][2]; sw_clr = VEC[i][1];
      @(negedge clk);
      chk(VREQ[i], {6'd0, q_out, qn_out}, {6'd0, VEC[i][0], ~VEC[i][0]});
      tick = 0; sw_set = 0; sw_clr = 0;
    end

    // R11: pin latency counted edge by edge
    quiet();
    pulse(1'b0);
    write_ctrl(8'h80);
    pin_in = 1;
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      chk("R11 pin not yet", {7'd0, q_out}, 8'h00);
    end
    @(negedge clk);
    chk("R11 pin arrives", {7'd0, q_out}, 8'h01);

    // R11: tick acts at first edge
    quiet();
    pulse(1'b0);
    write_ctrl(8'h40);
    tick = 1; @(negedge clk); tick = 0;
    chk("R11 tick first edge", {7'd0, q_out}, 8'h01);

    // R9: module enable
    quiet();
    pulse(1'b1);
    mod_en = 0; @(negedge clk);
    chk("R9 forced low", {6'd0, q_out, qn_out}, 8'h01);
    pulse(1'b1);
    chk("R9 set ignored", {7'd0, q_out}, 8'h00);
    mod_en = 1; @(negedge clk);
    chk("R9 stays low after enable", {7'd0, q_out}, 8'h00);

    // R10: output enables
    pulse(1'b1);
    q_oe = 0; #1;
    chk("R10 q gated", {6'd0, q_out, qn_out}, 8'h00);
    q_oe = 1; #1;
    chk("R10 q shown", {6'd0, q_out, qn_out}, 8'h02);
    @(negedge clk);
    pulse(1'b0);
    qn_oe = 0; #1;
    chk("R10 qn gated", {6'd0, q_out, qn_out}, 8'h00);
    qn_oe = 1; #1;
    chk("R10 qn shown", {6'd0, q_out, qn_out}, 8'h01);

    // R2: reset during operation
    @(negedge clk);
    write_ctrl(8'hFF);
    pulse(1'b1);
    rst_n = 0; #1;
    chk("R2 ctrl cleared", rd_data, 8'h00);
    chk("R2 q cleared", {7'd0, q_out}, 8'h00);
    @(negedge clk); rst_n = 1; @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule